// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast system clock into a one-cycle tick enable at a serial bit rate. The two clocks usually have no integer ratio, so it does not use a plain modulo-N counter. Each enabled clock, it adds a constant step into a wrap-around phase register of `ACC_W` bits. The carry out of that add becomes the tick. Over time the tick spacing alternates between the two integers on either side of the ideal ratio, and the average lands close to the target rate.

The step is computed at elaboration from the clock frequency, the bit rate and the oversampling factor. The formula rounds to the nearest integer and keeps every intermediate below 32 significant bits of headroom. With `OVERSAMPLE` set to 8, the block gives the 8x sampling tick a receiver needs. When the clock is an exact integer multiple of the requested rate, a plain modulo counter is generated instead. Downstream transmitters and receivers use `tick_o` as a clock enable.

Top module: `baud_tick_gen`

## Requirements
- R1: On each rising clock edge with `en_i` high, STEP is added to the ACC_W-bit phase, which starts at 0. `tick_o` is high in the following cycle exactly when that add carried out of bit ACC_W-1, and the phase keeps the low ACC_W bits of the sum.
- R2: STEP is the nearest integer to BAUD*OVERSAMPLE*2^ACC_W/CLK_HZ. Examples: 302 for 25 MHz, 115200, ACC_W=16; 59 for 2 MHz, 115200, ACC_W=10; 629 for 12 MHz, 115200, ACC_W=16.
- R3: `tick_o` is never high in two consecutive cycles while STEP is at most 2^(ACC_W-1).
- R4: An edge with `en_i` low produces no tick in the following cycle and leaves the phase unchanged, so later ticks follow as if that edge had not occurred.
- R5: `rst_ni` low clears `tick_o` and the phase at once, without waiting for a clock edge.
- R6: With OVERSAMPLE=8, STEP is computed from 8*BAUD, which gives eight times the tick rate.
- R7: When CLK_HZ is an exact multiple of BAUD*OVERSAMPLE, with ratio N, a counter replaces the phase register. `tick_o` is high in the cycle after every N-th enabled edge counted from reset.
- R8: Over a long run with `en_i` held high, the number of ticks stays within the STEP rounding error (plus one tick) of cycles*BAUD*OVERSAMPLE/CLK_HZ. That rounding error stays under 0.5% for the default parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance enable; low freezes the phase |
| tick_o | output | 1 | One-cycle rate tick |

## Verification
Four instances run side by side and share one enable:
- 25 MHz at 1x
- 25 MHz at 8x
- 2 MHz with a 10-bit phase
- 1.8432 MHz, which divides exactly and so takes the counter form

A bench model of the phase checks every tick position. Long runs with the enable held high expose a wrong step or a lost carry. Random enable patterns show whether phase is lost or a stray tick appears while disabled. A long disabled stretch shows whether the phase is held across it. A reset in the middle of a phase shows whether the phase is fully cleared. A final 60000-cycle count compares the measured rate with the ideal rate, using the error predicted from the rounded step.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // rounded step, intermediates kept small by pre-scaling both sides by 16
  function automatic longint unsigned calc_step(longint unsigned clk_hz,
                                                longint unsigned rate,
                                                int unsigned     acc_w);
    return ((rate << (acc_w - 4)) + (clk_hz >> 5)) / (clk_hz >> 4);
  endfunction

  function automatic bit is_exact(longint unsigned clk_hz, longint unsigned rate);
    return (clk_hz % rate) == 0;
  endfunction

  function automatic int unsigned cnt_width(longint unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/btg_phase_acc.sv
module btg_phase_acc #(
  parameter int unsigned     ACC_W = 16,
  parameter logic [ACC_W-1:0] STEP = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);

  logic [ACC_W:0] acc_q;
  logic [ACC_W:0] sum;

  assign sum = {1'b0, acc_q[ACC_W-1:0]} + {1'b0, STEP};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum;
    else           acc_q <= {1'b0, acc_q[ACC_W-1:0]};  // drop carry, hold phase
  end

  assign tick_o = acc_q[ACC_W];

  // R4
  idle_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q[ACC_W-1:0]));

  if (STEP <= (1 << (ACC_W - 1))) begin : g_single
    // R3
    single_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end

endmodule

// File: rtl/btg_mod_div.sv
module btg_mod_div #(
  parameter int unsigned N    = 16,
  parameter int unsigned CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (en_i) begin
      tick_q <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R7
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> (cnt_q == '0));

  // R4
  div_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!tick_q && $stable(cnt_q)));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 25_000_000,
  parameter int unsigned BAUD       = 115_200,
  parameter int unsigned ACC_W      = 16,
  parameter int unsigned OVERSAMPLE = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);

  localparam longint unsigned RATE  = longint'(BAUD) * longint'(OVERSAMPLE);
  localparam bit              EXACT = is_exact(longint'(CLK_HZ), RATE);
  localparam longint unsigned DIV_N = longint'(CLK_HZ) / RATE;
  localparam int unsigned     CNT_W = cnt_width(DIV_N);
  localparam logic [ACC_W-1:0] STEP =
    ACC_W'(calc_step(longint'(CLK_HZ), RATE, ACC_W));

  if (EXACT) begin : g_div
    btg_mod_div #(
      .N    (int'(DIV_N)),
      .CNT_W(CNT_W)
    ) u_div (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .tick_o(tick_o)
    );
  end else begin : g_acc
    btg_phase_acc #(
      .ACC_W(ACC_W),
      .STEP (STEP)
    ) u_acc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .tick_o(tick_o)
    );
  end

  // R5
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> !tick_o);

endmodule

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic t0, t1, t2, t3;

  always #2.5 clk = ~clk;

  baud_tick_gen #(.CLK_HZ(25_000_000), .BAUD(115_200), .ACC_W(16), .OVERSAMPLE(1))
    uut (.clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .tick_o(t0));
  baud_tick_gen #(.CLK_HZ(25_000_000), .BAUD(115_200), .ACC_W(16), .OVERSAMPLE(8))
    uut_os8 (.clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .tick_o(t1));
  baud_tick_gen #(.CLK_HZ(2_000_000), .BAUD(115_200), .ACC_W(10), .OVERSAMPLE(1))
    uut_small (.clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .tick_o(t2));
  baud_tick_gen #(.CLK_HZ(1_843_200), .BAUD(115_200), .ACC_W(16), .OVERSAMPLE(1))
    uut_div (.clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .tick_o(t3));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic longint ref_step(real clk_hz, real rate, int w);
    return longint'($rtoi(rate * (2.0 ** w) / clk_hz + 0.5));
  endfunction

  longint st0, st1, st2;
  longint p0, p1, p2, c3;
  bit     e0, e1, e2, e3;
  int     mism [4];
  longint fa [4], fe [4];
  bit     prev [4];
  int     b2b = 0;
  int     idle_ticks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clr_mism();
    for (int i = 0; i < 4; i++) begin mism[i] = 0; fa[i] = 0; fe[i] = 0; end
  endtask

  task automatic note(input int i, input bit a, input bit e);
    if (a !== e) begin
      if (mism[i] == 0) begin fa[i] = longint'(a); fe[i] = longint'(e); end
      mism[i]++;
    end
    if (a && prev[i]) b2b++;
    prev[i] = a;
  endtask

  task automatic model_reset();
    p0 = 0; p1 = 0; p2 = 0; c3 = 0;
    e0 = 0; e1 = 0; e2 = 0; e3 = 0;
    for (int i = 0; i < 4; i++) prev[i] = 0;
  endtask

  // called at a negedge: compare, drive, advance model
  task automatic cycle(input bit en);
    longint s;
    note(0, t0, e0); note(1, t1, e1); note(2, t2, e2); note(3, t3, e3);
    en_i = en;
    if (en) begin
      s = p0 + st0; e0 = (s >= 65536); p0 = s % 65536;
      s = p1 + st1; e1 = (s >= 65536); p1 = s % 65536;
      s = p2 + st2; e2 = (s >= 1024);  p2 = s % 1024;
      e3 = (c3 == 15); c3 = (c3 + 1) % 16;
    end else begin
      e0 = 0; e1 = 0; e2 = 0; e3 = 0;
    end
    @(negedge clk);
  endtask

  task automatic report(input string r0, input string r1, input string r2, input string r3);
    chk(mism[0] == 0, r0, "uut tick stream", fa[0], fe[0]);
    chk(mism[1] == 0, r1, "uut_os8 tick stream", fa[1], fe[1]);
    chk(mism[2] == 0, r2, "uut_small tick stream", fa[2], fe[2]);
    chk(mism[3] == 0, r3, "uut_div tick stream", fa[3], fe[3]);
    clr_mism();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int ticks;
    real ideal, err, tol;
    void'($urandom(32'd20240611));
    st0 = ref_step(25.0e6, 115200.0, 16);
    st1 = ref_step(25.0e6, 921600.0, 16);
    st2 = ref_step(2.0e6, 115200.0, 10);
    model_reset(); clr_mism();

    // R5 reset state
    repeat (3) @(negedge clk);
    chk(t0 == 0, "R5", "uut in reset", t0, 0);
    chk(t1 == 0, "R5", "uut_os8 in reset", t1, 0);
    chk(t2 == 0, "R5", "uut_small in reset", t2, 0);
    chk(t3 == 0, "R5", "uut_div in reset", t3, 0);
    rst_ni = 1'b1;

    // R2 known step values
    chk(st0 == 302, "R2", "bench step 25MHz", st0, 302);
    chk(st2 == 59, "R2", "bench step 2MHz", st2, 59);

    // R1 R2 R6 R7 continuous enable
    for (int k = 0; k < 3000; k++) cycle(1'b1);
    report("R1", "R6", "R2", "R7");

    // R4 random enable
    for (int k = 0; k < 20000; k++) cycle(($urandom % 4) != 0);
    report("R4", "R4", "R4", "R4");

    // R4 long idle then resume
    for (int k = 0; k < 500; k++) begin
      if (k > 0 && (t0 | t1 | t2 | t3)) idle_ticks++;
      cycle(1'b0);
    end
    chk(idle_ticks == 0, "R4", "ticks while idle", idle_ticks, 0);
    for (int k = 0; k < 1500; k++) cycle(($urandom % 8) != 0);
    report("R4", "R4", "R4", "R4");

    // R5 async reset mid phase
    for (int k = 0; k < 777; k++) cycle(1'b1);
    clr_mism();
    rst_ni = 1'b0;
    #1;
    chk((t0 | t1 | t2 | t3) == 0, "R5", "ticks right after async reset", t0 | t1 | t2 | t3, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
    for (int k = 0; k < 3000; k++) cycle(1'b1);
    report("R5", "R5", "R5", "R7");

    // R8 long-run rate
    ticks = 0;
    for (int k = 0; k < 60000; k++) begin
      if (t0) ticks++;
      cycle(1'b1);
    end
    ideal = 60000.0 * 115200.0 / 25.0e6;
    err = ((st0 * 25.0e6 / 65536.0) - 115200.0) / 115200.0;
    if (err < 0) err = -err;
    tol = ideal * err + 1.0;
    chk((ticks - ideal <= tol) && (ideal - ticks <= tol), "R8", "uut tick count",
        ticks, $rtoi(ideal));
    chk(err < 0.005, "R8", "predicted error ppm", $rtoi(err * 1.0e6), 5000);
    report("R8", "R8", "R8", "R8");

    // R3 across whole run
    chk(b2b == 0, "R3", "back-to-back ticks", b2b, 0);
    finish_run();
  end

endmodule